// File: doc/BRIEF.md
# Periodic Auto-Reload Interrupt Timer

This block is a 16-bit down-counting timer that raises a periodic interrupt toward the host. A prescaler divides the system clock into a coarse tick; with the default divider setting and a 200 MHz clock, one tick lasts 100 µs. Each tick lowers the count by one. When a tick finds the count already at zero, the count is refilled from a 16-bit reload value and counting carries on, so the interrupt period is (reload + 1) ticks.

The reload value is written one byte at a time through two write strobes that share one byte-wide data bus. A level enable starts the timer. Its rising edge restarts the prescaler and copies the reload value into the count. The interrupt has no status bit of its own. It stays asserted until the host reads the shared interrupt status register, and that read clears it. Decoding of the host bus and the other interrupt sources are handled outside the block.

Top module: `reload_tick_timer`

## Requirements
- R1: After reset `irq` is low, and both the reload value and the count equal 0xFFFF. Enabling without any write therefore gives a first expiry after 65536 ticks.
- R2: While `tmr_en` is high, one tick is produced every `TICK_DIV` clock cycles. The prescaler restarts from zero on the cycle that `tmr_en` goes from low to high, and no tick is produced while `tmr_en` is low.
- R3: On the clock edge that sees `tmr_en` rise, the count is loaded with the reload value that was held before that edge.
- R4: Each tick that finds the count non-zero decrements it by one. A tick that finds the count at zero reloads it and raises `irq` on the same edge. After enabling, the first rise of `irq` is therefore (P+1)·`TICK_DIV` cycles after the loading edge, and rises repeat every (P+1)·`TICK_DIV` cycles.
- R5: `wr_lo` writes `wr_data` into reload bits 7:0, and `wr_hi` writes it into bits 15:8. A new reload value does not change the count in progress and takes effect at the next reload or at the next enable.
- R6: Once high, `irq` stays high until a cycle with `isr_rd` high. After that edge it is low, unless R7 applies.
- R7: If an expiry and an `isr_rd` fall on the same cycle, `irq` is high after that edge.
- R8: While `tmr_en` is low, the count does not change and no new interrupt is raised. An interrupt that is already pending stays pending until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_lo | input | 1 | Write strobe for reload bits 7:0 |
| wr_hi | input | 1 | Write strobe for reload bits 15:8 |
| wr_data | input | 8 | Write data byte |
| tmr_en | input | 1 | Timer enable (level) |
| isr_rd | input | 1 | One-cycle strobe marking a host read of the interrupt status register |
| irq | output | 1 | Timer interrupt, held until read |

## Verification
Two functions can act on `irq` in the same cycle: an expiry that sets it and a status read that clears it. The bench follows the design's state in a cycle-level reference model. From that model it predicts the cycle of the next expiry while an interrupt is already pending, and it asserts `isr_rd` on exactly that cycle. On the next cycle `irq` must still be high, and a later read on its own must clear it. Random reads, writes and enable toggles over short reload values also produce further collisions of the same kind, and each one is judged cycle by cycle against the model.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned TMR_CNT_W  = 16;
  localparam int unsigned TMR_BYTE_W = 8;
  localparam int unsigned TMR_DIV    = 20000;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned TICK_DIV = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic at_top;

  assign at_top = (div_q == DIV_TOP);

  always_comb begin
    div_d = div_q;
    if (!run || restart) begin
      div_d = '0;
    end else if (at_top) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick = run && !restart && at_top;
endmodule

// File: rtl/preload_reg.sv
module preload_reg #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [CNT_W/BYTE_W-1:0]       wr_strb,
  input  logic [BYTE_W-1:0]             wr_data,
  output logic [CNT_W-1:0]              preload
);
  localparam int unsigned NLANE = CNT_W / BYTE_W;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q, lane_d;
    logic              lane_ce;

    assign lane_ce = wr_strb[g];

    always_comb begin
      lane_d = lane_q;
      if (lane_ce) lane_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '1;
      else        lane_q <= lane_d;
    end

    assign preload[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/down_counter.sv
module down_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = tick && at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = preload;
    end else if (tick) begin
      if (at_zero) cnt_d = preload;
      else         cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = irq_q;
    if (clr) irq_d = 1'b0;
    if (set) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/reload_tick_timer.sv
module reload_tick_timer
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W    = TMR_CNT_W,
  parameter int unsigned BYTE_W   = TMR_BYTE_W,
  parameter int unsigned TICK_DIV = TMR_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tmr_en,
  input  logic              isr_rd,
  output logic              irq
);
  localparam int unsigned NLANE = CNT_W / BYTE_W;

  logic             en_q, en_d;
  logic             start;
  logic             tick;
  logic             expire;
  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] count;
  logic [NLANE-1:0] wr_strb;

  always_comb begin
    wr_strb    = '0;
    wr_strb[0] = wr_lo;
    wr_strb[NLANE-1] = wr_strb[NLANE-1] | wr_hi;
  end

  always_comb en_d = tmr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign start = tmr_en && !en_q;

  tick_divider #(.TICK_DIV(TICK_DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (tmr_en),
    .restart (start),
    .tick    (tick)
  );

  preload_reg #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_strb (wr_strb),
    .wr_data (wr_data),
    .preload (preload)
  );

  down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tick    (tick),
    .preload (preload),
    .count   (count),
    .expire  (expire)
  );

  irq_latch u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire),
    .clr   (isr_rd),
    .irq   (irq)
  );
endmodule

// File: rtl/reload_tick_timer_chk.sv
module reload_tick_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_en,
  input logic             isr_rd,
  input logic             irq,
  input logic             tick,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] preload
);
  // R2: ticks only while enabled
  p_tick_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> tmr_en);

  // R3: rising enable loads the reload value
  p_load_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_en) |=> (count == $past(preload)));

  // R6: pending interrupt holds without a read
  p_hold_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !isr_rd) |=> irq);

  // R6: a read without expiry clears it
  p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && isr_rd && !expire) |=> !irq);

  // R7: expiry wins over a coinciding read
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> irq);

  // R8: no new interrupt while disabled
  p_quiet_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !irq) |=> !irq);

  // R8: count frozen while disabled
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && $past(!tmr_en)) |-> $stable(count));
endmodule

bind reload_tick_timer reload_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tmr_en  (tmr_en),
  .isr_rd  (isr_rd),
  .irq     (irq),
  .tick    (tick),
  .expire  (expire),
  .count   (count),
  .preload (preload)
);

// File: tb/reload_tick_timer_tb.sv
`timescale 1ns/1ps
module reload_tick_timer_tb;
  localparam int unsigned D = 3;

  logic       clk;
  logic       rst_n;
  logic       wr_lo, wr_hi, tmr_en, isr_rd;
  logic [7:0] wr_data;
  logic       irq;
  logic       en_f;
  logic       irq_f;

  int n_tests = 0;
  int n_fail  = 0;
  bit ls_on   = 0;

  reload_tick_timer #(.TICK_DIV(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .tmr_en(tmr_en), .isr_rd(isr_rd), .irq(irq)
  );

  reload_tick_timer #(.TICK_DIV(1)) u_dut_fast (
    .clk(clk), .rst_n(rst_n), .wr_lo(1'b0), .wr_hi(1'b0),
    .wr_data(8'h00), .tmr_en(en_f), .isr_rd(1'b0), .irq(irq_f)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model state
  logic [15:0] m_pl, m_cnt;
  int          m_div;
  logic        m_enq, m_irq;

  function automatic int exp_first(input int p, input int d);
    return (p + 1) * d + 1;
  endfunction

  function automatic int exp_period(input int p, input int d);
    return (p + 1) * d;
  endfunction

  function automatic bit exp_next_expire();
    return tmr_en && m_enq && (m_div == D - 1) && (m_cnt == 16'h0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pl = 16'hFFFF; m_cnt = 16'hFFFF; m_div = 0; m_enq = 0; m_irq = 0;
    end else begin
      bit st, tk, ex;
      st = tmr_en && !m_enq;
      tk = tmr_en && !st && (m_div == D - 1);
      ex = tk && (m_cnt == 16'h0);
      m_irq = ex || (m_irq && !isr_rd);
      if (st) m_cnt = m_pl;
      else if (tk) m_cnt = (m_cnt == 16'h0) ? m_pl : m_cnt - 16'h1;
      if (!tmr_en || st || m_div == D - 1) m_div = 0;
      else m_div = m_div + 1;
      if (wr_lo) m_pl[7:0]  = wr_data;
      if (wr_hi) m_pl[15:8] = wr_data;
      m_enq = tmr_en;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lockstep comparison of irq against the model (R4, R6, R7)
  always @(negedge clk) begin
    if (ls_on) check(irq == m_irq, "R4/R6 lockstep irq", int'(irq), int'(m_irq));
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 200000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic idle();
    wr_lo = 0; wr_hi = 0; isr_rd = 0;
  endtask

  task automatic set_preload(input logic [15:0] v);
    wr_lo = 1; wr_data = v[7:0];
    @(negedge clk);
    wr_lo = 0; wr_hi = 1; wr_data = v[15:8];
    @(negedge clk);
    wr_hi = 0;
  endtask

  task automatic count_to_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 1000);
  endtask

  task automatic read_once();
    isr_rd = 1;
    @(negedge clk);
    isr_rd = 0;
  endtask

  initial begin
    int n;
    int p;
    void'($urandom(32'd4242));
    rst_n = 0; en_f = 0; tmr_en = 0; wr_data = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ls_on = 1;

    check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);
    check(irq_f == 1'b0, "R1 irq_f after reset", int'(irq_f), 0);

    // R1: default reload 0xFFFF on the fast instance
    en_f = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq_f && n < 70000);
    check(n == exp_first(65535, 1), "R1 default reload period", n, exp_first(65535, 1));
    en_f = 0;

    // R5 + R3 + R4 + R2: program P=2 and enable
    set_preload(16'h0002);
    tmr_en = 1;
    count_to_irq(n);
    check(n == exp_first(2, D), "R4 first expiry after enable", n, exp_first(2, D));

    // R6: held without read
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R6 irq held without read", int'(irq), 1);
    read_once();
    check(irq == 1'b0, "R6 read clears irq", int'(irq), 0);

    // R4 periodic interval
    count_to_irq(n);
    n = 0;
    isr_rd = 1; wr_lo = 1; wr_data = 8'h05; // R5: write right after reload
    @(negedge clk); n++;
    isr_rd = 0; wr_lo = 0;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    check(n == exp_period(2, D), "R5 running count unaffected by write", n, exp_period(2, D));
    read_once(); n = 1;
    while (!irq && n < 1000) begin @(negedge clk); n++; end
    check(n == exp_period(5, D), "R5 new reload used at next reload", n, exp_period(5, D));

    // R7: read coinciding with expiry while pending
    while (!exp_next_expire()) @(negedge clk);
    isr_rd = 1;
    @(negedge clk);
    isr_rd = 0;
    check(irq == 1'b1, "R7 expiry beats coincident read", int'(irq), 1);
    read_once();
    check(irq == 1'b0, "R7 later read clears", int'(irq), 0);

    // R8: disable freezes and stays quiet
    tmr_en = 0;
    repeat (60) @(negedge clk);
    check(irq == 1'b0, "R8 no interrupt while disabled", int'(irq), 0);

    // R2: prescaler restart on re-enable, P=0
    set_preload(16'h0000);
    tmr_en = 1;
    count_to_irq(n);
    check(n == exp_first(0, D), "R2 tick spacing after re-enable", n, exp_first(0, D));
    read_once();

    // R8: pending irq survives disable
    count_to_irq(n);
    tmr_en = 0;
    repeat (10) @(negedge clk);
    check(irq == 1'b1, "R8 pending irq kept while disabled", int'(irq), 1);
    read_once();
    check(irq == 1'b0, "R8 read clears while disabled", int'(irq), 0);

    // random phase, checked by the lockstep model
    tmr_en = 1;
    for (int i = 0; i < 20000; i++) begin
      isr_rd = ($urandom % 6) == 0;
      wr_lo  = ($urandom % 50) == 0;
      wr_hi  = !wr_lo && (($urandom % 300) == 0);
      p      = $urandom % 6;
      wr_data = wr_hi ? 8'h00 : 8'(p);
      if (($urandom % 200) == 0) tmr_en = !tmr_en;
      @(negedge clk);
    end
    idle();
    @(negedge clk);

    ls_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule